// File: doc/BRIEF.md
# PCI Single-Cycle Memory Target

This block is the target side of a 32-bit parallel PCI bus, reduced to single-data-phase transfers. It watches the shared bus for the start of a transaction and captures the address and command on the first clock where FRAME# is low. If the address falls in its 64-byte window and the command is a memory read or a memory write, it claims the cycle with medium-speed DEVSEL#. It then holds off TRDY# for a programmable number of wait states and completes one 32-bit word against a small internal register file. Writes honour the byte enables.

All bus control pins are active low. The AD bus is split into an input, an output and an output enable, so a pad ring or a bus model can merge them. On a read, the target leaves AD undriven for the turnaround clock that follows the address phase. After the data handshake it releases DEVSEL#, TRDY# and AD. Configuration cycles, I/O cycles, parity, bursts, retry, disconnect and target-abort are not handled. Cycles of those kinds are simply left unclaimed.

Top module: `pci_target`

## Requirements
- R1: While reset is high and after it drops with the bus idle, devsel_n and trdy_n are 1, ad_oe is 0 and ad_out is 0.
- R2: A transaction is claimed only if its address phase meets all three conditions: frame_n was high on the previous clock; ad_in[31:6] equals BASE_ADDR[31:6] with ad_in[1:0] = 00; and cbe_n is 0110 (memory read) or 0111 (memory write). Any other transaction, including I/O (0010/0011) and configuration (1010/1011) commands and addresses outside the window, leaves devsel_n, trdy_n and ad_oe deasserted.
- R3: For a claimed transaction, devsel_n goes low in the second clock after the address phase and stays low until the transfer ends.
- R4: In the clock right after the address phase, ad_oe is 0. ad_oe is never 1 during a write or outside a claimed read.
- R5: trdy_n goes low exactly WAIT_STATES clocks after devsel_n goes low.
- R6: On a claimed read, ad_out carries the addressed register, with ad_oe at 1, in every clock where trdy_n is low.
- R7: A write is committed only at the clock edge where irdy_n and trdy_n are both low. While irdy_n stays high, trdy_n is held low and the data on ad_in is not stored.
- R8: In the data phase of a write, cbe_n[i] = 0 enables byte lane i (ad_in[8i+7:8i]). Lanes with cbe_n[i] = 1 keep their old contents.
- R9: In the clock after the irdy_n/trdy_n handshake, devsel_n and trdy_n are 1 and ad_oe is 0.
- R10: The register file holds 16 words, selected by address bits [5:2], and all words reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Transaction framing from initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| cbe_n | input | 4 | Command in address phase, byte enables (active low) in data phase |
| ad_in | input | 32 | Address/data bus as seen at the pins |
| ad_out | output | 32 | Read data toward the bus, 0 when not driving |
| ad_oe | output | 1 | Output enable for ad_out |
| devsel_n | output | 1 | Cycle claimed, active low |
| trdy_n | output | 1 | Target ready, active low |

## Verification
A wrong decode latch or a wrong state shows up at the pins within two clocks of the address phase. A foreign cycle is claimed, or devsel_n falls one clock early or late. A wrong wait counter moves the trdy_n edge by whole clocks, so the bench checks the exact clock of that edge. A corrupted register or a lane-mask fault stays hidden until a later read of the same word. For that reason every write in the bench is read back, and the reads also cover the words that unclaimed writes might have touched.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;

    // Bus command codes carried on cbe_n during the address phase
    typedef enum logic [3:0] {
        CMD_IO_RD  = 4'b0010,
        CMD_IO_WR  = 4'b0011,
        CMD_MEM_RD = 4'b0110,
        CMD_MEM_WR = 4'b0111,
        CMD_CFG_RD = 4'b1010,
        CMD_CFG_WR = 4'b1011
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TURN,
        ST_WAIT,
        ST_XFER
    } tgt_state_e;

    function automatic logic is_mem_cmd(input logic [3:0] code);
        return (code == CMD_MEM_RD) || (code == CMD_MEM_WR);
    endfunction

    // Replace only the lanes whose enable bit is set
    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_word,
        input logic [DATA_W-1:0] new_word,
        input logic [LANES-1:0]  lane_en
    );
        logic [DATA_W-1:0] res;
        res = old_word;
        for (int b = 0; b < LANES; b++) begin
            if (lane_en[b]) res[b*8 +: 8] = new_word[b*8 +: 8];
        end
        return res;
    endfunction

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter logic [DATA_W-1:0] BASE_ADDR = 32'hA000_0100,
    parameter int unsigned       IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [3:0]        cbe_n,
    input  logic              idle,
    output logic              start,
    output logic [IDX_W-1:0]  lat_idx,
    output logic              lat_wr
);
    localparam int unsigned WIN_BITS = IDX_W + 2;

    logic frame_q;
    logic addr_phase;
    logic hit;

    assign addr_phase = idle && frame_q && !frame_n;
    assign hit = (ad_in[DATA_W-1:WIN_BITS] == BASE_ADDR[DATA_W-1:WIN_BITS])
              && (ad_in[1:0] == 2'b00)
              && is_mem_cmd(cbe_n);
    assign start = addr_phase && hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= 1'b1;
            lat_idx <= '0;
            lat_wr  <= 1'b0;
        end else begin
            frame_q <= frame_n;
            if (addr_phase) begin
                lat_idx <= ad_in[WIN_BITS-1:2];
                lat_wr  <= cbe_n[0];
            end
        end
    end

endmodule

// File: rtl/pci_tgt_seq.sv
module pci_tgt_seq
    import pci_tgt_pkg::*;
#(
    parameter int unsigned WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_wr,
    input  logic irdy_n,
    output logic idle,
    output logic devsel_n,
    output logic trdy_n,
    output logic drive,
    output logic commit
);
    localparam int unsigned CW = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1;

    tgt_state_e    state;
    logic [CW-1:0] cnt;
    logic          claimed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) state <= ST_TURN;
                ST_TURN: begin
                    if (WAIT_STATES == 0) begin
                        state <= ST_XFER;
                    end else begin
                        state <= ST_WAIT;
                        cnt   <= CW'(WAIT_STATES);
                    end
                end
                ST_WAIT: begin
                    cnt <= cnt - CW'(1);
                    if (cnt == CW'(1)) state <= ST_XFER;
                end
                ST_XFER: if (!irdy_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign claimed  = (state == ST_WAIT) || (state == ST_XFER);
    assign idle     = (state == ST_IDLE);
    assign devsel_n = !claimed;
    assign trdy_n   = (state != ST_XFER);
    assign drive    = claimed && !is_wr;
    assign commit   = (state == ST_XFER) && !irdy_n;

endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile
    import pci_tgt_pkg::*;
#(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [NUM_REGS-1:0][DATA_W-1:0] rows;

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_row
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (idx == IDX_W'(r))) begin
                q <= merge_lanes(q, wdata, lane_en);
            end
        end
        assign rows[r] = q;
    end

    assign rdata = rows[idx];

endmodule

// File: rtl/pci_target.sv
module pci_target
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'hA000_0100,
    parameter int unsigned NUM_REGS    = 16,
    parameter int unsigned WAIT_STATES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n,
    output logic        trdy_n
);
    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic             idle;
    logic             start;
    logic [IDX_W-1:0] cur_idx;
    logic             cyc_wr;
    logic             commit;
    logic             wr_en;
    logic [31:0]      rd_word;

    pci_tgt_decode #(
        .BASE_ADDR (BASE_ADDR),
        .IDX_W     (IDX_W)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .frame_n (frame_n),
        .ad_in   (ad_in),
        .cbe_n   (cbe_n),
        .idle    (idle),
        .start   (start),
        .lat_idx (cur_idx),
        .lat_wr  (cyc_wr)
    );

    pci_tgt_seq #(
        .WAIT_STATES (WAIT_STATES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .is_wr    (cyc_wr),
        .irdy_n   (irdy_n),
        .idle     (idle),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .drive    (ad_oe),
        .commit   (commit)
    );

    assign wr_en = commit && cyc_wr;

    pci_tgt_regfile #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .idx     (cur_idx),
        .lane_en (~cbe_n),
        .wdata   (ad_in),
        .rdata   (rd_word)
    );

    assign ad_out = ad_oe ? rd_word : '0;

endmodule

// File: rtl/pci_target_chk.sv
module pci_target_chk #(
    parameter int unsigned WAIT_STATES = 2
) (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic irdy_n,
    input logic devsel_n,
    input logic trdy_n,
    input logic ad_oe,
    input logic cyc_wr,
    input logic wr_en
);
    logic [7:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst || devsel_n) hold_cnt <= '0;
        else if (trdy_n && hold_cnt != 8'hFF) hold_cnt <= hold_cnt + 8'd1;
    end

    // R3: claim appears two clocks after a FRAME# falling edge
    a_r3_devsel_medium: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> (!$past(frame_n, 2) && $past(frame_n, 3)));

    // R4: AD is only driven inside a claimed read
    a_r4_drive_claimed_read: assert property (@(posedge clk) disable iff (rst)
        ad_oe |-> (!devsel_n && !cyc_wr));

    // R5: wait-state count before TRDY#
    a_r5_wait_count: assert property (@(posedge clk) disable iff (rst)
        $fell(trdy_n) |-> (hold_cnt == 8'(WAIT_STATES)));

    // R6: TRDY# never without DEVSEL#
    a_r6_trdy_claimed: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> !devsel_n);

    // R7: storage only on the handshake edge, TRDY# held while initiator waits
    a_r7_commit_handshake: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!irdy_n && !trdy_n));

    a_r7_trdy_hold: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && irdy_n) |=> !trdy_n);

    // R9: everything released after the handshake
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (!trdy_n && !irdy_n) |=> (devsel_n && trdy_n && !ad_oe));

endmodule

bind pci_target pci_target_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .ad_oe    (ad_oe),
    .cyc_wr   (cyc_wr),
    .wr_en    (wr_en)
);

// File: tb/tb_pci_target.sv
module tb_pci_target;

    localparam logic [31:0] BASE = 32'hA000_0100;
    localparam int unsigned W    = 2;

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  cmd;
        logic [3:0]  be_n;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        claim;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{BASE + 32'h0C, 4'b0111, 4'b0000, 32'hDEAD_BEEF, 32'h0,         1'b1},
        '{BASE + 32'h0C, 4'b0110, 4'b0000, 32'h0,         32'hDEAD_BEEF, 1'b1},
        '{BASE + 32'h0C, 4'b0111, 4'b1010, 32'h1122_3344, 32'h0,         1'b1},
        '{BASE + 32'h0C, 4'b0110, 4'b0000, 32'h0,         32'hDE22_BE44, 1'b1},
        '{BASE + 32'h3C, 4'b0111, 4'b0000, 32'h0F0F_0F0F, 32'h0,         1'b1},
        '{BASE + 32'h3C, 4'b0110, 4'b0000, 32'h0,         32'h0F0F_0F0F, 1'b1},
        '{BASE + 32'h40, 4'b0111, 4'b0000, 32'hFFFF_FFFF, 32'h0,         1'b0},
        '{BASE + 32'h00, 4'b0110, 4'b0000, 32'h0,         32'h0,         1'b1},
        '{BASE + 32'h00, 4'b0011, 4'b0000, 32'h1234_5678, 32'h0,         1'b0},
        '{BASE + 32'h00, 4'b0110, 4'b0000, 32'h0,         32'h0,         1'b1},
        '{BASE + 32'h00, 4'b0111, 4'b1110, 32'h1234_56AA, 32'h0,         1'b1},
        '{BASE + 32'h00, 4'b0110, 4'b0000, 32'h0,         32'h0000_00AA, 1'b1},
        '{BASE + 32'h00, 4'b1010, 4'b0000, 32'h0,         32'h0,         1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_n;
    logic        irdy_n;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in;
    logic [31:0] ad_out;
    logic        ad_oe;
    logic        devsel_n;
    logic        trdy_n;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pci_target #(
        .BASE_ADDR   (BASE),
        .NUM_REGS    (16),
        .WAIT_STATES (W)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .cbe_n    (cbe_n),
        .ad_in    (ad_in),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] pins();
        return {28'h0, ad_oe, trdy_n, devsel_n, 1'b0};
    endfunction

    task automatic run_vec(input vec_t v, input int n);
        bit rd;
        rd = (v.cmd[0] == 1'b0);
        frame_n = 1'b0; ad_in = v.addr; cbe_n = v.cmd; irdy_n = 1'b1;
        step();
        check(devsel_n && trdy_n && !ad_oe, $sformatf("R4 turnaround vec %0d", n), pins(), 32'h6);
        frame_n = 1'b0 | 1'b1; irdy_n = 1'b0; cbe_n = v.be_n;
        ad_in = rd ? 32'h0BAD_F00D : v.wdata;
        step();
        check(devsel_n == !v.claim, $sformatf("R2 R3 devsel vec %0d", n), {31'h0, devsel_n}, {31'h0, !v.claim});
        check(trdy_n, $sformatf("R5 early trdy vec %0d", n), {31'h0, trdy_n}, 32'h1);
        for (int i = 0; i < int'(W) - 1; i++) begin
            step();
            check(trdy_n && (devsel_n == !v.claim), $sformatf("R5 wait vec %0d", n), pins(), 32'h0);
        end
        step();
        if (v.claim) begin
            check(!trdy_n && !devsel_n, $sformatf("R5 trdy on time vec %0d", n), pins(), 32'h0);
            if (rd) check(ad_oe && ad_out == v.exp, $sformatf("R6 R10 read data vec %0d", n), ad_out, v.exp);
            else    check(!ad_oe, $sformatf("R4 no drive on write vec %0d", n), pins(), 32'h0);
        end else begin
            check(trdy_n && devsel_n && !ad_oe, $sformatf("R2 unclaimed vec %0d", n), pins(), 32'h6);
        end
        step();
        check(devsel_n && trdy_n && !ad_oe, $sformatf("R9 release vec %0d", n), pins(), 32'h6);
        irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        repeat (3) step();
        check(devsel_n && trdy_n && !ad_oe && ad_out == 0, "R1 in reset", pins(), 32'h6);
        rst = 1'b0;
        step();
        check(devsel_n && trdy_n && !ad_oe && ad_out == 0, "R1 after reset", pins(), 32'h6);

        // R10 R8 R2 table walk
        for (int n = 0; n < NV; n++) run_vec(VEC[n], n);

        // R7: initiator holds IRDY# high; TRDY# must wait and no early store
        frame_n = 1'b0; ad_in = BASE + 32'h14; cbe_n = 4'b0111; irdy_n = 1'b1;
        step();
        cbe_n = 4'b0000; ad_in = 32'hBADB_AD00;
        for (int i = 0; i < int'(W) + 1; i++) step();
        check(!trdy_n, "R7 trdy low awaiting irdy", {31'h0, trdy_n}, 32'h0);
        for (int i = 0; i < 3; i++) begin
            ad_in = 32'hBADB_AD00 + 32'(i);
            step();
            check(!trdy_n && !devsel_n, "R7 trdy held", pins(), 32'h0);
        end
        frame_n = 1'b1; irdy_n = 1'b0; ad_in = 32'h5555_AAAA;
        step();
        check(devsel_n && trdy_n, "R9 release after late irdy", pins(), 32'h6);
        irdy_n = 1'b1; cbe_n = 4'hF; ad_in = '0;
        step();
        run_vec('{BASE + 32'h14, 4'b0110, 4'b0000, 32'h0, 32'h5555_AAAA, 1'b1}, 100);
        // R8 R10: word 3 must still hold the merged value
        run_vec('{BASE + 32'h0C, 4'b0110, 4'b0000, 32'h0, 32'hDE22_BE44, 1'b1}, 101);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule